// File: doc/BRIEF.md
# Rule Scheduler and Update Combiner

This block is the per-cycle control core for a set of guarded atomic actions, called rules, that all update one shared bank of state registers. Each cycle, every rule offers a ready predicate and one proposed data value. The block decides which rules fire. It then decides, for each register, whether the register loads and what value it loads.

Rules are sorted into conflict groups. Each group has its own fixed-priority arbiter, so at most one rule per group fires in a cycle. Rules in different groups are free to fire together. A per-register combiner merges the proposals of the fired writers with AND-OR gating. When two fired writers have different sequential ranks, the higher rank takes precedence. Writers of equal rank are assumed mutually exclusive or conflict-free, and their proposals are ORed.

Three things are elaboration-time parameters: the group of each rule, the map of which rule writes which register, and the rank of each rule. Predicate logic and conflict analysis live outside the block.

Top module: `rule_sched_top`

## Requirements
- R1: `fire_o[i]` is high only in a cycle where `ready_i[i]` is high.
- R2: In every conflict group that has at least one ready rule, at least one rule of that group fires in the same cycle. Default groups: rules 0,1,2 form group 0; rules 3,4 form group 1; rules 5,6,7 form group 2.
- R3: In each conflict group, at most one rule fires per cycle.
- R4: Within a group, the ready rule with the lowest index is the one that fires.
- R5: Rules in different groups fire in the same cycle when they are ready together.
- R6: `wen_o[k]` is the OR of the fire bits of all rules that write register k. The default write map is: rule0 writes reg0; rule1 writes reg0 and reg1; rule2 writes reg1 and reg3; rule3 writes reg0; rules 4 and 5 write reg2; rules 6 and 7 write reg3.
- R7: A register whose `wen_o` bit is low keeps its value. A proposal from a rule that did not fire has no effect.
- R8: When fired writers of one register share the same rank, the register loads the OR of their proposals. In the defaults, rule2 and rule6 both write reg3 with rank 0.
- R9: When fired writers of one register have different ranks, the register loads the proposal of the highest-ranked one. Default ranks are rule3 = 1, rule5 = 1, and every other rule = 0.
- R10: `rst_ni` low clears every register to zero at once, and the registers stay at zero while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; registers update on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ready_i | input | N_RULES | Ready predicate per rule |
| value_i | input | N_RULES x DATA_W | Proposed value per rule |
| fire_o | output | N_RULES | Fire decision per rule |
| wen_o | output | N_REGS | Load enable per register |
| state_o | output | N_REGS x DATA_W | Current register contents |

## Verification
In one cycle, the bench fires rules from two different groups that target the same register. This happens in two forms:
- Rules 1 and 3 both write reg0, and rules 4 and 5 both write reg2. These pairs have different ranks, so only the higher-ranked proposal may land.
- Rules 2 and 6 both write reg3 with equal rank, so the two proposals must merge by OR.

The proposal values use disjoint bit patterns, so the loaded value shows exactly which writers contributed. A final cycle forces every proposal to all ones while no rule, or only one rule, is ready. This shows that unfired proposals leave every register untouched.

// File: rtl/rule_sched_pkg.sv
package rule_sched_pkg;
  localparam int unsigned DEF_RULES  = 8;
  localparam int unsigned DEF_REGS   = 4;
  localparam int unsigned DEF_WIDTH  = 16;
  localparam int unsigned DEF_GROUPS = 3;
  localparam int unsigned DEF_GRP_W  = 2;
  localparam int unsigned DEF_RANK_W = 2;
  // rule7 .. rule0
  localparam logic [DEF_RULES-1:0][DEF_GRP_W-1:0]  DEF_GROUP_OF  = 16'hA940;
  localparam logic [DEF_RULES-1:0][DEF_REGS-1:0]   DEF_WRITE_MAP = 32'h8844_1A31;
  localparam logic [DEF_RULES-1:0][DEF_RANK_W-1:0] DEF_SEQ_RANK  = 16'h0440;
endpackage

// File: rtl/rule_grp_arbiter.sv
module rule_grp_arbiter #(
  parameter int unsigned        N_RULES = 8,
  parameter logic [N_RULES-1:0] MEMBERS = '1
) (
  input  logic [N_RULES-1:0] req_i,
  output logic [N_RULES-1:0] grant_o
);
  logic taken;

  // lowest index among member requests wins
  always_comb begin
    grant_o = '0;
    taken   = 1'b0;
    for (int i = 0; i < N_RULES; i++) begin
      if (MEMBERS[i] && req_i[i] && !taken) begin
        grant_o[i] = 1'b1;
        taken      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rule_fire_sched.sv
module rule_fire_sched #(
  parameter int unsigned N_RULES  = 8,
  parameter int unsigned N_GROUPS = 3,
  parameter int unsigned GRP_W    = 2,
  parameter logic [N_RULES-1:0][GRP_W-1:0] GROUP_OF = '0
) (
  input  logic [N_RULES-1:0] ready_i,
  output logic [N_RULES-1:0] fire_o
);
  function automatic logic [N_RULES-1:0] members_of(logic [GRP_W-1:0] g);
    logic [N_RULES-1:0] m;
    for (int i = 0; i < N_RULES; i++) m[i] = (GROUP_OF[i] == g);
    return m;
  endfunction

  logic [N_RULES-1:0] grant [N_GROUPS];

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    rule_grp_arbiter #(
      .N_RULES(N_RULES),
      .MEMBERS(members_of(GRP_W'(g)))
    ) u_arb (
      .req_i  (ready_i),
      .grant_o(grant[g])
    );
  end

  // groups are disjoint, so grants merge by OR
  always_comb begin
    fire_o = '0;
    for (int g = 0; g < N_GROUPS; g++) fire_o = fire_o | grant[g];
  end
endmodule

// File: rtl/rule_write_combiner.sv
module rule_write_combiner #(
  parameter int unsigned N_RULES = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned RANK_W  = 2,
  parameter logic [N_RULES-1:0] WRITERS = '0,
  parameter logic [N_RULES-1:0][RANK_W-1:0] SEQ_RANK = '0
) (
  input  logic [N_RULES-1:0]             fire_i,
  input  logic [N_RULES-1:0][DATA_W-1:0] value_i,
  output logic                           en_o,
  output logic [DATA_W-1:0]              next_o
);
  logic [N_RULES-1:0] kill;
  logic [N_RULES-1:0] pass;

  // a fired writer of higher rank overrides lower ranks
  always_comb begin
    kill = '0;
    for (int i = 0; i < N_RULES; i++) begin
      for (int j = 0; j < N_RULES; j++) begin
        if (WRITERS[j] && (SEQ_RANK[j] > SEQ_RANK[i])) kill[i] = kill[i] | fire_i[j];
      end
    end
  end

  assign pass = fire_i & WRITERS & ~kill;

  always_comb begin
    next_o = '0;
    for (int i = 0; i < N_RULES; i++) next_o = next_o | (value_i[i] & {DATA_W{pass[i]}});
  end

  assign en_o = |(fire_i & WRITERS);
endmodule

// File: rtl/rule_state_bank.sv
module rule_state_bank #(
  parameter int unsigned N_REGS = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REGS-1:0]             en_i,
  input  logic [N_REGS-1:0][DATA_W-1:0] next_i,
  output logic [N_REGS-1:0][DATA_W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= '0;
    end else begin
      for (int k = 0; k < N_REGS; k++) begin
        if (en_i[k]) state_o[k] <= next_i[k];
      end
    end
  end
endmodule

// File: rtl/rule_sched_top.sv
module rule_sched_top
  import rule_sched_pkg::*;
#(
  parameter int unsigned N_RULES  = DEF_RULES,
  parameter int unsigned N_REGS   = DEF_REGS,
  parameter int unsigned DATA_W   = DEF_WIDTH,
  parameter int unsigned N_GROUPS = DEF_GROUPS,
  parameter int unsigned GRP_W    = DEF_GRP_W,
  parameter int unsigned RANK_W   = DEF_RANK_W,
  parameter logic [N_RULES-1:0][GRP_W-1:0]  GROUP_OF  = DEF_GROUP_OF,
  parameter logic [N_RULES-1:0][N_REGS-1:0] WRITE_MAP = DEF_WRITE_MAP,
  parameter logic [N_RULES-1:0][RANK_W-1:0] SEQ_RANK  = DEF_SEQ_RANK
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_RULES-1:0]            ready_i,
  input  logic [N_RULES-1:0][DATA_W-1:0] value_i,
  output logic [N_RULES-1:0]            fire_o,
  output logic [N_REGS-1:0]             wen_o,
  output logic [N_REGS-1:0][DATA_W-1:0] state_o
);
  function automatic logic [N_RULES-1:0] writers_of(int unsigned k);
    logic [N_RULES-1:0] w;
    for (int i = 0; i < N_RULES; i++) w[i] = WRITE_MAP[i][k];
    return w;
  endfunction

  logic [N_REGS-1:0][DATA_W-1:0] next_val;

  rule_fire_sched #(
    .N_RULES (N_RULES),
    .N_GROUPS(N_GROUPS),
    .GRP_W   (GRP_W),
    .GROUP_OF(GROUP_OF)
  ) u_sched (
    .ready_i(ready_i),
    .fire_o (fire_o)
  );

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    rule_write_combiner #(
      .N_RULES (N_RULES),
      .DATA_W  (DATA_W),
      .RANK_W  (RANK_W),
      .WRITERS (writers_of(k)),
      .SEQ_RANK(SEQ_RANK)
    ) u_comb (
      .fire_i (fire_o),
      .value_i(value_i),
      .en_o   (wen_o[k]),
      .next_o (next_val[k])
    );
  end

  rule_state_bank #(
    .N_REGS(N_REGS),
    .DATA_W(DATA_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wen_o),
    .next_i (next_val),
    .state_o(state_o)
  );
endmodule

// File: rtl/rule_sched_chk.sv
module rule_sched_chk #(
  parameter int unsigned N_RULES  = 8,
  parameter int unsigned N_REGS   = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned N_GROUPS = 3,
  parameter int unsigned GRP_W    = 2,
  parameter logic [N_RULES-1:0][GRP_W-1:0]  GROUP_OF  = '0,
  parameter logic [N_RULES-1:0][N_REGS-1:0] WRITE_MAP = '0
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [N_RULES-1:0]            ready_i,
  input logic [N_RULES-1:0]            fire_o,
  input logic [N_REGS-1:0]             wen_o,
  input logic [N_REGS-1:0][DATA_W-1:0] state_o
);
  function automatic logic [N_RULES-1:0] members_of(logic [GRP_W-1:0] g);
    logic [N_RULES-1:0] m;
    for (int i = 0; i < N_RULES; i++) m[i] = (GROUP_OF[i] == g);
    return m;
  endfunction

  function automatic logic [N_RULES-1:0] writers_of(int unsigned k);
    logic [N_RULES-1:0] w;
    for (int i = 0; i < N_RULES; i++) w[i] = WRITE_MAP[i][k];
    return w;
  endfunction

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    localparam logic [N_RULES-1:0] GM = members_of(GRP_W'(g));
    a_r2_group_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(ready_i & GM)) |-> (|(fire_o & GM)));
    a_r3_group_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(fire_o & GM));
  end

  for (genvar i = 0; i < N_RULES; i++) begin : g_rule
    localparam logic [N_RULES-1:0] AHEAD = members_of(GROUP_OF[i]) & ((N_RULES'(1) << i) - N_RULES'(1));
    a_r1_fire_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o[i] |-> ready_i[i]);
    a_r4_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o[i] |-> ((ready_i & AHEAD) == '0));
  end

  for (genvar k = 0; k < N_REGS; k++) begin : g_reg
    localparam logic [N_RULES-1:0] WR = writers_of(k);
    a_r6_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wen_o[k] == (|(fire_o & WR)));
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wen_o[k] |=> (state_o[k] == $past(state_o[k])));
  end
endmodule

bind rule_sched_top rule_sched_chk #(
  .N_RULES  (N_RULES),
  .N_REGS   (N_REGS),
  .DATA_W   (DATA_W),
  .N_GROUPS (N_GROUPS),
  .GRP_W    (GRP_W),
  .GROUP_OF (GROUP_OF),
  .WRITE_MAP(WRITE_MAP)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ready_i(ready_i),
  .fire_o (fire_o),
  .wen_o  (wen_o),
  .state_o(state_o)
);

// File: tb/sim_rule_sched_top.sv
module sim_rule_sched_top;
  localparam int N = 8;
  localparam int K = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic                 rst_n;
  logic [N-1:0]         ready;
  logic [N-1:0][W-1:0]  vals;
  logic [N-1:0]         fire;
  logic [K-1:0]         wen;
  logic [K-1:0][W-1:0]  state;

  rule_sched_top u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .ready_i(ready),
    .value_i(vals),
    .fire_o (fire),
    .wen_o  (wen),
    .state_o(state)
  );

  typedef struct {
    logic [N-1:0] fire;
    logic [K-1:0] wen;
    logic [W-1:0] st [K];
    string        tag;
  } item_t;

  item_t q[$];
  int errs = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic set_vals(bit hot);
    for (int i = 0; i < N; i++) vals[i] = 16'hFFFF;
    if (!hot) begin
      vals[0] = 16'h0011; vals[1] = 16'h0022; vals[2] = 16'h0404; vals[3] = 16'h0030;
      vals[4] = 16'h0050; vals[5] = 16'h0600; vals[6] = 16'h7000; vals[7] = 16'h8008;
    end
  endtask

  task automatic drive(logic [N-1:0] rdy, bit hot, logic [N-1:0] ef, logic [K-1:0] ew,
                       logic [W-1:0] s0, logic [W-1:0] s1, logic [W-1:0] s2, logic [W-1:0] s3,
                       string tag);
    item_t it;
    @(negedge clk);
    ready = rdy;
    set_vals(hot);
    it.fire = ef; it.wen = ew; it.tag = tag;
    it.st[0] = s0; it.st[1] = s1; it.st[2] = s2; it.st[3] = s3;
    q.push_back(it);
  endtask

  // monitor: combinational outputs and the freshly loaded state just after the edge
  initial begin
    forever begin
      item_t it;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "fire", 64'(fire), 64'(it.fire));
        chk(it.tag, "wen", 64'(wen), 64'(it.wen));
        for (int k = 0; k < K; k++) chk(it.tag, $sformatf("state%0d", k), 64'(state[k]), 64'(it.st[k]));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ready = '0;
    set_vals(1'b0);
    #5;
    for (int k = 0; k < K; k++) chk("R10", "reset state", 64'(state[k]), 64'h0);
    chk("R1", "fire idle", 64'(fire), 64'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    drive(8'h00, 0, 8'h00, 4'b0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R7");
    drive(8'h01, 0, 8'h01, 4'b0001, 16'h0011, 16'h0000, 16'h0000, 16'h0000, "R6");
    drive(8'h07, 0, 8'h01, 4'b0001, 16'h0011, 16'h0000, 16'h0000, 16'h0000, "R4");
    drive(8'h06, 0, 8'h02, 4'b0011, 16'h0022, 16'h0022, 16'h0000, 16'h0000, "R4");
    drive(8'h04, 0, 8'h04, 4'b1010, 16'h0022, 16'h0404, 16'h0000, 16'h0404, "R6");
    drive(8'h10, 0, 8'h10, 4'b0100, 16'h0022, 16'h0404, 16'h0050, 16'h0404, "R2");
    drive(8'h0A, 0, 8'h0A, 4'b0011, 16'h0030, 16'h0022, 16'h0050, 16'h0404, "R9");
    drive(8'h30, 0, 8'h30, 4'b0100, 16'h0030, 16'h0022, 16'h0600, 16'h0404, "R5");
    drive(8'hE0, 0, 8'h20, 4'b0100, 16'h0030, 16'h0022, 16'h0600, 16'h0404, "R3");
    drive(8'hC4, 0, 8'h44, 4'b1010, 16'h0030, 16'h0404, 16'h0600, 16'h7404, "R8");
    drive(8'h81, 0, 8'h81, 4'b1001, 16'h0011, 16'h0404, 16'h0600, 16'h8008, "R5");
    drive(8'hFF, 0, 8'h29, 4'b0101, 16'h0030, 16'h0404, 16'h0600, 16'h8008, "R9");
    drive(8'h00, 1, 8'h00, 4'b0000, 16'h0030, 16'h0404, 16'h0600, 16'h8008, "R7");
    drive(8'h01, 1, 8'h01, 4'b0001, 16'hFFFF, 16'h0404, 16'h0600, 16'h8008, "R1");

    wait (q.size() == 0);
    @(negedge clk);
    ready = '0;
    set_vals(1'b0);
    rst_n = 1'b0;
    #1;
    for (int k = 0; k < K; k++) chk("R10", "async clear", 64'(state[k]), 64'h0);
    ready = 8'hFF;
    @(posedge clk);
    #1;
    for (int k = 0; k < K; k++) chk("R10", "held in reset", 64'(state[k]), 64'h0);
    finish_run();
  end
endmodule